// File: doc/BRIEF.md
# Alarm and Periodic Update Interrupt Unit

This block sits beside a real-time clock core and turns its time-of-day values into two interrupt events: a periodic update event and a calendar alarm. The clock core supplies BCD seconds, minutes, hours and day-of-month, a one-hot weekday, and a polling strobe that may arrive more often than once a second. The unit evaluates its events only when it sees a seconds value that differs from the one it last evaluated. In practice this means one evaluation per second.

The update event fires on every new second, or only on a change of minute, depending on a select input. The alarm fires at second zero when the stored minute, hour and day bytes all match the current time. The day byte is compared either against the one-hot weekday or against the BCD day of month, depending on a second select input. Each event sets its own sticky flag. Software clears the flags through dedicated inputs. Any event in an evaluation produces one single-cycle interrupt pulse.

Top module: `ai_irq_unit`

## Requirements
- R1: After reset, `upd_flag_o`, `alm_flag_o` and `irq_o` are all 0.
- R2: With `upd_en_i`=1 and `upd_minute_i`=0, every evaluation sets `upd_flag_o` and pulses `irq_o`. Both are visible one clock after the polling cycle.
- R3: With `upd_minute_i`=1, an update event occurs only when `min_i` differs from the last recorded minute, and that minute is then recorded. A rising edge of `upd_en_i` records the current minute, so the first event waits for the next minute change.
- R4: An evaluation happens only in a cycle with `poll_i`=1 whose `sec_i` differs from the seconds value of the previous evaluation. A rising edge of either enable records the current seconds and starts no evaluation in that cycle.
- R5: With `alm_en_i`=1, an evaluation with `sec_i`=8'h00, `alm_min_i`==`min_i` and `alm_hour_i`==`hour_i`, together with a matching day byte, sets `alm_flag_o` and pulses `irq_o`.
- R6: When `alm_day_mode_i`=1, `alm_day_i` must equal `mday_i`. When it is 0, `alm_day_i` must equal the weekday zero-extended to a byte, where bit 0 is the first day of the week and one bit is set per day.
- R7: All alarm comparisons are exact full-byte matches, so a set upper bit in an alarm byte prevents the match.
- R8: When the update event and the alarm occur in the same evaluation, both flags are set and `irq_o` is high for exactly one cycle.
- R9: A flag stays set until its clear input is asserted. If a set and a clear of the same flag occur in the same cycle, the set wins.
- R10: While both enables are 0, no evaluation happens: `irq_o` stays 0 and the flags keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_i | input | 1 | Sampling strobe from the clock core |
| sec_i | input | 8 | Current seconds, BCD |
| min_i | input | 8 | Current minutes, BCD |
| hour_i | input | 8 | Current hours, BCD |
| mday_i | input | 8 | Current day of month, BCD |
| wday_i | input | 7 | Current weekday, one-hot |
| alm_min_i | input | 8 | Alarm minute byte |
| alm_hour_i | input | 8 | Alarm hour byte |
| alm_day_i | input | 8 | Alarm day byte (weekday or day of month) |
| upd_en_i | input | 1 | Update event enable |
| upd_minute_i | input | 1 | Update select: 0 every second, 1 per minute change |
| alm_en_i | input | 1 | Alarm enable |
| alm_day_mode_i | input | 1 | Alarm day select: 0 weekday, 1 day of month |
| upd_clr_i | input | 1 | Clear the update flag |
| alm_clr_i | input | 1 | Clear the alarm flag |
| upd_flag_o | output | 1 | Sticky update flag |
| alm_flag_o | output | 1 | Sticky alarm flag |
| irq_o | output | 1 | Single-cycle interrupt pulse |

## Verification
The bench sweeps all 49 pairs of current weekday and alarm weekday, and a grid of days of month in the other day mode. A swapped or inverted day select would show up as alarms that are missed or spurious.

The bench repeats the polling strobe with an unchanged seconds value. A design that evaluated on every strobe would pulse several times per second.

In per-minute mode, the bench enables the update event in the middle of a minute. A design that did not record the minute on the enable edge would fire at once.

The bench also checks three more cases:
- An alarm byte with a stray upper bit must not match. A design that masked the upper bits would fire here.
- A coincident update event and alarm must give exactly one pulse. A design that produced two would fail this check.
- A set and a clear in the same cycle must leave the flag set. A design that gave the clear priority would lose the event.

// File: rtl/ai_pkg.sv
package ai_pkg;

    typedef enum logic {
        DAY_BY_WEEKDAY = 1'b0,
        DAY_BY_MDAY    = 1'b1
    } day_mode_e;

    typedef struct packed {
        logic upd;
        logic alm;
    } ai_evt_t;

endpackage

// File: rtl/ai_alarm_cmp.sv
module ai_alarm_cmp #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned WDAY_W = 7
) (
    input  logic [BYTE_W-1:0] sec_i,
    input  logic [BYTE_W-1:0] min_i,
    input  logic [BYTE_W-1:0] hour_i,
    input  logic [BYTE_W-1:0] mday_i,
    input  logic [WDAY_W-1:0] wday_i,
    input  logic [BYTE_W-1:0] alm_min_i,
    input  logic [BYTE_W-1:0] alm_hour_i,
    input  logic [BYTE_W-1:0] alm_day_i,
    input  ai_pkg::day_mode_e day_mode_i,
    output logic              hit_o
);
    localparam int unsigned PAD_W = BYTE_W - WDAY_W;

    logic [BYTE_W-1:0] wday_byte;
    logic              day_ok;

    always_comb begin
        wday_byte = {{PAD_W{1'b0}}, wday_i};
        if (day_mode_i == ai_pkg::DAY_BY_MDAY) begin
            day_ok = (alm_day_i == mday_i);
        end else begin
            day_ok = (alm_day_i == wday_byte);
        end
        hit_o = (sec_i == '0) && (alm_min_i == min_i) &&
                (alm_hour_i == hour_i) && day_ok;
    end
endmodule

// File: rtl/ai_update_sel.sv
module ai_update_sel #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              en_i,
    input  logic              per_minute_i,
    input  logic [BYTE_W-1:0] min_i,
    input  logic [BYTE_W-1:0] last_min_i,
    output logic              fire_o,
    output logic              take_min_o
);
    always_comb begin
        if (!en_i) begin
            fire_o     = 1'b0;
            take_min_o = 1'b0;
        end else if (per_minute_i) begin
            fire_o     = (min_i != last_min_i);
            take_min_o = fire_o;
        end else begin
            fire_o     = 1'b1;
            take_min_o = 1'b0;
        end
    end
endmodule

// File: rtl/ai_irq_unit.sv
module ai_irq_unit #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned WDAY_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll_i,
    input  logic [BYTE_W-1:0] sec_i,
    input  logic [BYTE_W-1:0] min_i,
    input  logic [BYTE_W-1:0] hour_i,
    input  logic [BYTE_W-1:0] mday_i,
    input  logic [WDAY_W-1:0] wday_i,
    input  logic [BYTE_W-1:0] alm_min_i,
    input  logic [BYTE_W-1:0] alm_hour_i,
    input  logic [BYTE_W-1:0] alm_day_i,
    input  logic              upd_en_i,
    input  logic              upd_minute_i,
    input  logic              alm_en_i,
    input  logic              alm_day_mode_i,
    input  logic              upd_clr_i,
    input  logic              alm_clr_i,
    output logic              upd_flag_o,
    output logic              alm_flag_o,
    output logic              irq_o
);
    import ai_pkg::*;

    typedef struct packed {
        logic [BYTE_W-1:0] last_sec;
        logic [BYTE_W-1:0] last_min;
        logic              upd_en_prev;
        logic              alm_en_prev;
        logic              upd_flag;
        logic              alm_flag;
        logic              irq;
    } state_t;

    state_t    st_d, st_q;
    day_mode_e day_mode;
    logic      alm_match;
    logic      upd_fire;
    logic      upd_take_min;
    logic      upd_rise, alm_rise;
    logic      eval;
    ai_evt_t   evt;

    assign day_mode = day_mode_e'(alm_day_mode_i);

    ai_alarm_cmp #(.BYTE_W(BYTE_W), .WDAY_W(WDAY_W)) u_cmp (
        .sec_i      (sec_i),
        .min_i      (min_i),
        .hour_i     (hour_i),
        .mday_i     (mday_i),
        .wday_i     (wday_i),
        .alm_min_i  (alm_min_i),
        .alm_hour_i (alm_hour_i),
        .alm_day_i  (alm_day_i),
        .day_mode_i (day_mode),
        .hit_o      (alm_match)
    );

    ai_update_sel #(.BYTE_W(BYTE_W)) u_upd (
        .en_i         (upd_en_i),
        .per_minute_i (upd_minute_i),
        .min_i        (min_i),
        .last_min_i   (st_q.last_min),
        .fire_o       (upd_fire),
        .take_min_o   (upd_take_min)
    );

    always_comb begin
        st_d             = st_q;
        st_d.upd_en_prev = upd_en_i;
        st_d.alm_en_prev = alm_en_i;
        st_d.irq         = 1'b0;

        upd_rise = upd_en_i & ~st_q.upd_en_prev;
        alm_rise = alm_en_i & ~st_q.alm_en_prev;

        // An enable edge snapshots the current time instead of evaluating.
        if (upd_rise) begin
            st_d.last_min = min_i;
            st_d.last_sec = sec_i;
        end
        if (alm_rise) begin
            st_d.last_sec = sec_i;
        end

        eval = poll_i & (upd_en_i | alm_en_i) & ~upd_rise & ~alm_rise &
               (sec_i != st_q.last_sec);

        evt.upd = eval & upd_fire;
        evt.alm = eval & alm_en_i & alm_match;

        if (eval) begin
            st_d.last_sec = sec_i;
        end
        if (evt.upd && upd_take_min) begin
            st_d.last_min = min_i;
        end

        // Set takes priority over a simultaneous clear.
        if (upd_clr_i) st_d.upd_flag = 1'b0;
        if (alm_clr_i) st_d.alm_flag = 1'b0;
        if (evt.upd)   st_d.upd_flag = 1'b1;
        if (evt.alm)   st_d.alm_flag = 1'b1;

        st_d.irq = evt.upd | evt.alm;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign upd_flag_o = st_q.upd_flag;
    assign alm_flag_o = st_q.alm_flag;
    assign irq_o      = st_q.irq;
endmodule

// File: rtl/ai_irq_chk.sv
module ai_irq_chk #(
    parameter int unsigned BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              poll_i,
    input logic [BYTE_W-1:0] sec_i,
    input logic              upd_en_i,
    input logic              alm_en_i,
    input logic              upd_clr_i,
    input logic              alm_clr_i,
    input logic              upd_flag_o,
    input logic              alm_flag_o,
    input logic              irq_o
);
    // R1 R2
    irq_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (upd_flag_o || alm_flag_o));

    // R4
    no_poll_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_i |=> !irq_o);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en_i && !alm_en_i) |=> !irq_o);

    // R10
    idle_keeps_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en_i && !alm_en_i && !upd_clr_i) |=> $stable(upd_flag_o));

    // R5
    alarm_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag_o) |-> ($past(sec_i) == '0 && $past(alm_en_i)));

    // R2
    upd_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_flag_o) |-> $past(upd_en_i));

    // R9
    upd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_flag_o && !upd_clr_i) |=> upd_flag_o);

    // R9
    alm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_flag_o && !alm_clr_i) |=> alm_flag_o);
endmodule

bind ai_irq_unit ai_irq_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .poll_i     (poll_i),
    .sec_i      (sec_i),
    .upd_en_i   (upd_en_i),
    .alm_en_i   (alm_en_i),
    .upd_clr_i  (upd_clr_i),
    .alm_clr_i  (alm_clr_i),
    .upd_flag_o (upd_flag_o),
    .alm_flag_o (alm_flag_o),
    .irq_o      (irq_o)
);

// File: tb/sim_ai_irq_unit.sv
`timescale 1ns/1ps
module sim_ai_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       poll = 1'b0;
    logic [7:0] sec = 8'h00, mn = 8'h00, hr = 8'h00, mday = 8'h01;
    logic [6:0] wday = 7'h01;
    logic [7:0] a_min = 8'h00, a_hour = 8'h00, a_day = 8'h00;
    logic       upd_en = 1'b0, upd_minute = 1'b0, alm_en = 1'b0, day_mode = 1'b0;
    logic       upd_clr = 1'b0, alm_clr = 1'b0;
    logic       upd_flag, alm_flag, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ai_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .poll_i(poll), .sec_i(sec), .min_i(mn),
        .hour_i(hr), .mday_i(mday), .wday_i(wday), .alm_min_i(a_min),
        .alm_hour_i(a_hour), .alm_day_i(a_day), .upd_en_i(upd_en),
        .upd_minute_i(upd_minute), .alm_en_i(alm_en),
        .alm_day_mode_i(day_mode), .upd_clr_i(upd_clr), .alm_clr_i(alm_clr),
        .upd_flag_o(upd_flag), .alm_flag_o(alm_flag), .irq_o(irq)
    );

    function automatic logic [7:0] bcd(input int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present a seconds value with the strobe for one cycle; outputs are
    // valid at the negedge that follows.
    task automatic poll_sec(input logic [7:0] s);
        @(negedge clk);
        sec  = s;
        poll = 1'b1;
        @(negedge clk);
        poll = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        upd_clr = 1'b1;
        alm_clr = 1'b1;
        @(negedge clk);
        upd_clr = 1'b0;
        alm_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 upd_flag", {7'b0, upd_flag}, 8'h0);
        chk("R1 alm_flag", {7'b0, alm_flag}, 8'h0);
        chk("R1 irq", {7'b0, irq}, 8'h0);

        // R10: both enables off, seconds move, nothing happens
        for (int s = 1; s < 6; s++) begin
            poll_sec(bcd(s));
            chk("R10 idle irq", {7'b0, irq}, 8'h0);
            chk("R10 idle flag", {6'b0, upd_flag, alm_flag}, 8'h0);
        end

        // R2: per-second update over a full minute sweep
        sec = 8'h00;
        @(negedge clk);
        upd_en = 1'b1;
        idle(1);
        for (int s = 1; s < 60; s++) begin
            poll_sec(bcd(s));
            chk("R2 irq", {7'b0, irq}, 8'h1);
            chk("R2 upd_flag", {7'b0, upd_flag}, 8'h1);
            @(negedge clk);
            chk("R8 pulse one cycle", {7'b0, irq}, 8'h0);
            // R4: repeated strobe with unchanged seconds
            poll_sec(bcd(s));
            chk("R4 same sec", {7'b0, irq}, 8'h0);
            clear_all();
            chk("R9 cleared", {7'b0, upd_flag}, 8'h0);
        end

        // R9: set and clear in the same cycle, set wins
        @(negedge clk);
        sec = 8'h07; poll = 1'b1; upd_clr = 1'b1;
        @(negedge clk);
        poll = 1'b0; upd_clr = 1'b0;
        chk("R9 set wins", {7'b0, upd_flag}, 8'h1);
        idle(3);
        chk("R9 sticky", {7'b0, upd_flag}, 8'h1);

        // R10: flags held while disabled
        upd_en = 1'b0;
        for (int s = 10; s < 14; s++) begin
            poll_sec(bcd(s));
            chk("R10 flag held", {7'b0, upd_flag}, 8'h1);
            chk("R10 no irq", {7'b0, irq}, 8'h0);
        end
        clear_all();

        // R4: enable edge records seconds, same value does not evaluate
        @(negedge clk);
        sec = 8'h20;
        upd_en = 1'b1;
        idle(1);
        poll_sec(8'h20);
        chk("R4 enable snapshot", {7'b0, irq}, 8'h0);
        poll_sec(8'h21);
        chk("R4 next sec", {7'b0, irq}, 8'h1);
        clear_all();

        // R3: per-minute mode, first event waits for a minute change
        upd_en = 1'b0;
        upd_minute = 1'b1;
        mn = 8'h10;
        idle(1);
        upd_en = 1'b1;
        idle(1);
        for (int s = 22; s < 30; s++) begin
            poll_sec(bcd(s));
            chk("R3 same minute", {7'b0, irq}, 8'h0);
        end
        mn = 8'h11;
        poll_sec(8'h00);
        chk("R3 minute change irq", {7'b0, irq}, 8'h1);
        chk("R3 minute change flag", {7'b0, upd_flag}, 8'h1);
        clear_all();
        poll_sec(8'h01);
        chk("R3 no repeat", {7'b0, irq}, 8'h0);
        upd_en = 1'b0;
        upd_minute = 1'b0;
        clear_all();

        // R5 R6: weekday sweep, every current day against every alarm day
        mn = 8'h30; hr = 8'h08; a_min = 8'h30; a_hour = 8'h08;
        day_mode = 1'b0;
        alm_en = 1'b1;
        idle(1);
        for (int w = 0; w < 7; w++) begin
            for (int a = 0; a < 7; a++) begin
                wday  = 7'(1 << w);
                a_day = 8'(1 << a);
                poll_sec(8'h59);
                chk("R5 no alarm at sec 59", {7'b0, alm_flag}, 8'h0);
                poll_sec(8'h00);
                chk("R6 weekday match", {7'b0, alm_flag}, (w == a) ? 8'h1 : 8'h0);
                chk("R6 weekday irq", {7'b0, irq}, (w == a) ? 8'h1 : 8'h0);
                clear_all();
            end
        end

        // R6: day-of-month mode grid
        day_mode = 1'b1;
        wday = 7'h01;
        for (int d = 0; d < 4; d++) begin
            for (int a = 0; a < 4; a++) begin
                mday  = bcd(1 + d * 9);
                a_day = bcd(1 + a * 9);
                poll_sec(8'h58);
                poll_sec(8'h00);
                chk("R6 mday match", {7'b0, alm_flag}, (d == a) ? 8'h1 : 8'h0);
                clear_all();
            end
        end
        // weekday value in mday mode must not count
        mday = 8'h05; a_day = 8'h01;
        poll_sec(8'h33);
        poll_sec(8'h00);
        chk("R6 mode ignores weekday", {7'b0, alm_flag}, 8'h0);

        // R5: minute and hour mismatches
        a_day = 8'h05;
        a_min = 8'h31;
        poll_sec(8'h12);
        poll_sec(8'h00);
        chk("R5 minute mismatch", {7'b0, alm_flag}, 8'h0);
        a_min = 8'h30; a_hour = 8'h09;
        poll_sec(8'h13);
        poll_sec(8'h00);
        chk("R5 hour mismatch", {7'b0, alm_flag}, 8'h0);
        a_hour = 8'h08;

        // R7: stray upper bit in the alarm minute blocks the match
        a_min = 8'hB0;
        poll_sec(8'h14);
        poll_sec(8'h00);
        chk("R7 upper bit", {7'b0, alm_flag}, 8'h0);
        a_min = 8'h30;
        poll_sec(8'h15);
        poll_sec(8'h00);
        chk("R7 exact match", {7'b0, alm_flag}, 8'h1);
        clear_all();

        // R8: update and alarm in the same second give one pulse
        upd_en = 1'b1;
        idle(1);
        poll_sec(8'h16);
        clear_all();
        poll_sec(8'h00);
        chk("R8 upd flag", {7'b0, upd_flag}, 8'h1);
        chk("R8 alm flag", {7'b0, alm_flag}, 8'h1);
        chk("R8 irq", {7'b0, irq}, 8'h1);
        @(negedge clk);
        chk("R8 single pulse", {7'b0, irq}, 8'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule